// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block models a synchronous static RAM whose port is fully pipelined. Every command (address plus controls) is registered on a rising clock edge. The data belonging to that command crosses the bus two clock edges later, whether it is a read or a write. Because both directions use the same two-edge offset, a controller can issue reads and writes in any order on consecutive cycles. No idle bus cycle is needed when the traffic changes direction.

The shared bidirectional data bus is split into an input vector, an output vector and a drive enable, so the model synthesizes. An internal pipeline decides when the block drives the bus. An asynchronous active-low output enable can cut the drive at any moment. A clock enable freezes the whole block. Three chip enables of mixed polarity gate new commands. An advance/load line either loads a fresh address or steps a four-beat burst, in linear or interleaved order. The storage array is a reduced-depth register array. Each word has two byte lanes, and each lane holds 8 data bits and 1 parity bit.

Top module: `zbt_sram`

## Requirements
- R1: A read command registered at enabled edge N drives the addressed word on `dq_out`, with `dq_oe` high, in the cycle that ends with enabled edge N+2. The drive starts just after edge N+1.
- R2: A read may directly follow a write, and a write may directly follow a read, with no idle cycle between them. A read issued one cycle after a write to the same address returns the newly written data.
- R3: Write data and `byte_wr_n` are sampled at enabled edge N+2 for a write command registered at edge N. Lane 0 is `dq` bits 7:0 plus bit 16. Lane 1 is bits 15:8 plus bit 17. `byte_wr_n[i]` low writes lane i, and a high select leaves that lane unchanged.
- R4: While `clk_en_n` is high, every synchronous input is ignored and every register holds its value, including commands already in the pipeline, the burst state and the bus outputs.
- R5: The block is selected only when `sel1_n` is low, `sel2` is high and `sel3_n` is low. A load cycle in which any of the three is not asserted starts no operation, but commands already in the pipeline still complete.
- R6: The block does not drive the bus during the data slot of a write command or of a cycle with no operation.
- R7: When `out_en_n` is high, `dq_oe` is low at once, whatever the state of the pipeline.
- R8: `adv_load` low loads the external address. `adv_load` high continues the burst with the direction (read or write) captured at the last load. If that load was a deselect, a continue cycle performs no operation.
- R9: Beat k of a burst (k = 0 at the load, wrapping after 3) keeps address bits above bit 1 from the load address. With `burst_lin` high, bits 1:0 are the loaded bits plus k, modulo 4. With `burst_lin` low, they are the loaded bits XOR k.
- R10: After synchronous reset (`rst_n` low at a clock edge) the bus is not driven, the pipeline is empty and the last loaded operation is "none".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| sel1_n | input | 1 | Chip enable 1, active low |
| sel2 | input | 1 | Chip enable 2, active high |
| sel3_n | input | 1 | Chip enable 3, active low |
| adv_load | input | 1 | 0 = load new address, 1 = advance burst |
| rd_wr_n | input | 1 | 1 = read, 0 = write (sampled on load) |
| burst_lin | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | 6 | Word address |
| byte_wr_n | input | 2 | Active-low lane write selects, sampled with write data |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | 18 | Data bus, inbound half |
| dq_out | output | 18 | Data bus, outbound half |
| dq_oe | output | 1 | High when the block drives the bus |

## Verification
The assertions treat `clk_en_n`, the chip enables and `adv_load` as clean two-state values that are stable around each clock edge. They place no limit on how commands may be ordered, which includes bursts that continue after a deselect. The stimulus meets these conditions by changing inputs only on the falling edge and by drawing every control from `$urandom`. In most cycles the chip is selected and output is enabled, so reads, writes, stalls and deselects all occur often. A write pass over every address first sets the array to known contents, so every read has a defined expected value.

// File: rtl/zbt_sram_pkg.sv
// Shared types and helpers for the pipelined SRAM model.
// Assumes bursts of four beats addressed by the two low address bits.
package zbt_sram_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low address bits of burst beat cnt, linear or interleaved.
    function automatic logic [1:0] burst_pos(input logic [1:0] base,
                                             input logic [1:0] cnt,
                                             input logic       linear);
        return linear ? (base + cnt) : (base ^ cnt);
    endfunction

endpackage

// File: rtl/zbt_burst_ctl.sv
// Command stage: registers the address and operation of each cycle.
// A load takes the external address and, when the chip is selected, the
// direction. An advance steps a four-beat burst and reuses the direction of
// the last load. Assumes AW >= 3. Holds completely while hold is high.
module zbt_burst_ctl
    import zbt_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          load,
    input  logic          sel_ok,
    input  logic          rd_n_wr,
    input  logic          linear,
    input  logic [AW-1:0] addr,
    output op_e           op_q,
    output logic [AW-1:0] addr_q
);

    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic [1:0]    cnt_nxt;
    op_e           last_q;
    op_e           op_new;

    // Next beat count and the operation a load would start.
    always_comb begin
        cnt_nxt = cnt_q + 2'd1;
        if (!sel_ok)      op_new = OP_NONE;
        else if (rd_n_wr) op_new = OP_READ;
        else              op_new = OP_WRITE;
    end

    // Command register and burst state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_NONE;
            last_q <= OP_NONE;
            addr_q <= '0;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (!hold) begin
            if (load) begin
                base_q <= addr;
                cnt_q  <= '0;
                last_q <= op_new;
                op_q   <= op_new;
                addr_q <= addr;
            end else begin
                cnt_q  <= cnt_nxt;
                op_q   <= last_q;
                addr_q <= {base_q[AW-1:2], burst_pos(base_q[1:0], cnt_nxt, linear)};
            end
        end
    end

endmodule

// File: rtl/zbt_lane_store.sv
// One byte lane of the storage array (data bits plus parity bit).
// The read port is combinational and forwards a write to the same address
// in the same cycle, so a read never sees stale data. The array has no reset.
module zbt_lane_store #(
    parameter int AW = 6,
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [LW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [LW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [LW-1:0] mem [DEPTH];

    // Array write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read with forwarding of the write in the same cycle.
    always_comb begin
        rdata = (we && (waddr == raddr)) ? wdata : mem[raddr];
    end

endmodule

// File: rtl/zbt_sram.sv
// Pipelined synchronous SRAM with the same two-edge data offset for reads and
// writes. Stage 1 is the command register, stage 2 holds writes until their
// data arrives, and the read register drives the bus during the read's data
// slot. Assumes the bus is split into dq_in, dq_out and dq_oe by the user.
module zbt_sram
    import zbt_sram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clk_en_n,
    input  logic                        sel1_n,
    input  logic                        sel2,
    input  logic                        sel3_n,
    input  logic                        adv_load,
    input  logic                        rd_wr_n,
    input  logic                        burst_lin,
    input  logic [AW-1:0]               addr,
    input  logic [LANES-1:0]            byte_wr_n,
    input  logic                        out_en_n,
    input  logic [LANES*(BYTE_W+1)-1:0] dq_in,
    output logic [LANES*(BYTE_W+1)-1:0] dq_out,
    output logic                        dq_oe
);

    localparam int LW  = BYTE_W + 1;
    localparam int DQW = LANES * LW;
    localparam int PB  = LANES * BYTE_W;

    logic          hold;
    logic          sel_ok;
    op_e           s1_op;
    logic [AW-1:0] s1_addr;
    op_e           s2_op;
    logic [AW-1:0] s2_addr;
    logic          drive_q;
    logic [DQW-1:0] rd_q;
    logic [DQW-1:0] rd_word;
    logic [LANES-1:0] lane_we;

    // Decoded controls.
    always_comb begin
        hold   = clk_en_n;
        sel_ok = !sel1_n && sel2 && !sel3_n;
    end

    zbt_burst_ctl #(.AW(AW)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .load    (!adv_load),
        .sel_ok  (sel_ok),
        .rd_n_wr (rd_wr_n),
        .linear  (burst_lin),
        .addr    (addr),
        .op_q    (s1_op),
        .addr_q  (s1_addr)
    );

    // Second stage: the command whose data arrives at the next enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_op   <= OP_NONE;
            s2_addr <= '0;
        end else if (!hold) begin
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LW-1:0] wdata;
        logic [LW-1:0] rdata;

        // Lane write strobe and lane slice of the inbound word.
        always_comb begin
            lane_we[i] = !hold && (s2_op == OP_WRITE) && !byte_wr_n[i];
            wdata      = {dq_in[PB+i], dq_in[i*BYTE_W +: BYTE_W]};
        end

        zbt_lane_store #(.AW(AW), .LW(LW)) u_store (
            .clk   (clk),
            .we    (lane_we[i]),
            .waddr (s2_addr),
            .wdata (wdata),
            .raddr (s1_addr),
            .rdata (rdata)
        );

        assign rd_word[i*BYTE_W +: BYTE_W] = rdata[BYTE_W-1:0];
        assign rd_word[PB+i]               = rdata[BYTE_W];
    end

    // Read register: loads on a read command and drives the data slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
            rd_q    <= '0;
        end else if (!hold) begin
            drive_q <= (s1_op == OP_READ);
            if (s1_op == OP_READ) rd_q <= rd_word;
        end
    end

    // Bus outputs; the output enable acts without a clock.
    always_comb begin
        dq_out = rd_q;
        dq_oe  = drive_q && !out_en_n;
    end

endmodule

// File: rtl/zbt_sram_chk.sv
// Assertion checker for zbt_sram, attached by bind. Assumes inputs are
// two-state and stable at the rising edge.
module zbt_sram_chk
    import zbt_sram_pkg::*;
#(
    parameter int AW  = 6,
    parameter int DQW = 18
) (
    input logic           clk,
    input logic           rst_n,
    input logic           clk_en_n,
    input logic           adv_load,
    input logic           sel1_n,
    input logic           sel2,
    input logic           sel3_n,
    input logic           out_en_n,
    input logic           dq_oe,
    input logic [DQW-1:0] dq_out,
    input op_e            s1_op,
    input logic [AW-1:0]  s1_addr,
    input logic           drive_q
);

    logic chip_on;
    always_comb chip_on = !sel1_n && sel2 && !sel3_n;

    // R7: output enable high removes the drive at once.
    always_comb begin
        if (out_en_n) a_r7_async_off: assert (!dq_oe);
    end

    a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && s1_op == OP_READ) |=> drive_q);

    a_r6_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && s1_op != OP_READ) |=> !drive_q);

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(dq_out) && $stable(drive_q) && $stable(s1_op) && $stable(s1_addr)));

    a_r5_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_load && !chip_on) |=> (s1_op == OP_NONE));

    a_r8_keep_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_load) |=> (s1_op == $past(s1_op)));

    a_r9_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_load) |=> (s1_addr[AW-1:2] == $past(s1_addr[AW-1:2])));

endmodule

bind zbt_sram zbt_sram_chk #(.AW(AW), .DQW(DQW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .adv_load (adv_load),
    .sel1_n   (sel1_n),
    .sel2     (sel2),
    .sel3_n   (sel3_n),
    .out_en_n (out_en_n),
    .dq_oe    (dq_oe),
    .dq_out   (dq_out),
    .s1_op    (s1_op),
    .s1_addr  (s1_addr),
    .drive_q  (drive_q)
);

// File: tb/zbt_sram_tb.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a reference model built from the requirements.
module zbt_sram_tb;

    localparam int CLK_P = 10;
    localparam int AW    = 6;
    localparam int DQW   = 18;
    localparam int DEPTH = 1 << AW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           clk_en_n = 1'b0;
    logic           sel1_n = 1'b0;
    logic           sel2 = 1'b1;
    logic           sel3_n = 1'b0;
    logic           adv_load = 1'b0;
    logic           rd_wr_n = 1'b1;
    logic           burst_lin = 1'b1;
    logic [AW-1:0]  addr = '0;
    logic [1:0]     byte_wr_n = 2'b11;
    logic           out_en_n = 1'b0;
    logic [DQW-1:0] dq_in = '0;
    logic [DQW-1:0] dq_out;
    logic           dq_oe;

    int n_chk = 0;
    int n_bad = 0;

    // Reference state: ops 0 none, 1 read, 2 write.
    logic [DQW-1:0] mmem [DEPTH];
    int             m1_op = 0, m2_op = 0, last_op = 0;
    logic [AW-1:0]  m1_addr = '0, m2_addr = '0, b_base = '0;
    logic [1:0]     b_cnt = '0;
    logic           exp_oe = 1'b0;
    logic [DQW-1:0] exp_dq = '0;

    always #(CLK_P/2) clk = ~clk;

    zbt_sram u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n),
        .sel2(sel2), .sel3_n(sel3_n), .adv_load(adv_load), .rd_wr_n(rd_wr_n),
        .burst_lin(burst_lin), .addr(addr), .byte_wr_n(byte_wr_n),
        .out_en_n(out_en_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic check(input string tag, input logic [DQW-1:0] act, input logic [DQW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DQW-1:0] lane_mask(input int l);
        logic [DQW-1:0] m = '0;
        for (int b = 0; b < 8; b++) m[l*8+b] = 1'b1;
        m[16+l] = 1'b1;
        return m;
    endfunction

    function automatic logic [1:0] beat(input logic [1:0] base, input logic [1:0] k, input logic lin);
        return lin ? base + k : base ^ k;
    endfunction

    // One clock: update the model at the edge, check outputs on the falling edge.
    task automatic tick(input string tag);
        @(posedge clk);
        if (!rst_n) begin
            m1_op = 0; m2_op = 0; last_op = 0; exp_oe = 1'b0;
            m1_addr = '0; b_base = '0; b_cnt = '0;
        end else if (!clk_en_n) begin
            if (m2_op == 2)
                for (int l = 0; l < 2; l++)
                    if (!byte_wr_n[l])
                        mmem[m2_addr] = (mmem[m2_addr] & ~lane_mask(l)) | (dq_in & lane_mask(l));
            exp_oe = (m1_op == 1);
            if (exp_oe) exp_dq = mmem[m1_addr];
            m2_op = m1_op; m2_addr = m1_addr;
            if (!adv_load) begin
                b_base = addr; b_cnt = '0;
                last_op = (!sel1_n && sel2 && !sel3_n) ? (rd_wr_n ? 1 : 2) : 0;
                m1_op = last_op; m1_addr = addr;
            end else begin
                b_cnt = b_cnt + 2'd1;
                m1_op = last_op;
                m1_addr = {b_base[AW-1:2], beat(b_base[1:0], b_cnt, burst_lin)};
            end
        end
        @(negedge clk);
        check({tag, " drive"}, {17'd0, dq_oe}, {17'd0, exp_oe & !out_en_n});
        if (exp_oe && !out_en_n) check({tag, " data"}, dq_out, exp_dq);
    endtask

    task automatic cmd(input logic ld, input logic rd, input logic [AW-1:0] a,
                       input logic [1:0] bw, input string tag);
        clk_en_n = 1'b0; adv_load = !ld; rd_wr_n = rd; addr = a; byte_wr_n = bw;
        dq_in = DQW'($urandom);
        tick(tag);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        void'($urandom(32'd7321));
        for (int i = 0; i < DEPTH; i++) mmem[i] = '0;
        // R10: reset state
        rst_n = 1'b0;
        tick("R10"); tick("R10");
        check("R10 reset drive", {17'd0, dq_oe}, '0);
        rst_n = 1'b1;
        // Fill the array with full-lane writes.
        for (int i = 0; i < DEPTH; i++) cmd(1, 0, AW'(i), 2'b00, "R3");
        cmd(1, 1, 0, 2'b00, "R1"); cmd(1, 1, 1, 2'b00, "R1");
        // R2: write then immediate read, same address, alternating.
        cmd(1, 0, 5, 2'b11, "R2"); cmd(1, 1, 5, 2'b00, "R2");
        cmd(1, 0, 6, 2'b11, "R2"); cmd(1, 1, 6, 2'b00, "R2");
        cmd(1, 1, 7, 2'b00, "R2"); cmd(1, 0, 7, 2'b11, "R2");
        cmd(1, 1, 7, 2'b00, "R2");
        // R3: single-lane writes.
        cmd(1, 0, 9, 2'b01, "R3"); cmd(1, 0, 10, 2'b10, "R3");
        cmd(1, 1, 9, 2'b10, "R3"); cmd(1, 1, 10, 2'b11, "R3");
        cmd(1, 0, 11, 2'b11, "R3"); cmd(1, 1, 11, 2'b11, "R3");
        cmd(1, 1, 9, 2'b11, "R3");
        // R4: stall with a read and a write in flight; garbage held off.
        cmd(1, 0, 12, 2'b00, "R4"); cmd(1, 1, 12, 2'b00, "R4");
        for (int k = 0; k < 3; k++) begin
            clk_en_n = 1'b1; adv_load = 1'b0; rd_wr_n = 1'b0; addr = 13;
            byte_wr_n = 2'b00; dq_in = DQW'($urandom);
            tick("R4");
        end
        cmd(1, 1, 12, 2'b00, "R4"); cmd(1, 1, 13, 2'b00, "R4");
        // R5: each enable deasserted in turn behind a pending read.
        cmd(1, 1, 20, 2'b00, "R5");
        sel1_n = 1'b1; cmd(1, 1, 21, 2'b00, "R5"); sel1_n = 1'b0;
        sel2 = 1'b0;   cmd(1, 0, 22, 2'b00, "R5"); sel2 = 1'b1;
        sel3_n = 1'b1; cmd(1, 1, 23, 2'b00, "R5"); sel3_n = 1'b0;
        cmd(1, 1, 22, 2'b00, "R6"); cmd(1, 1, 23, 2'b00, "R6");
        // R7: output enable cut while read data is pending.
        cmd(1, 1, 30, 2'b00, "R7");
        out_en_n = 1'b1; #1;
        check("R7 async off", {17'd0, dq_oe}, '0);
        cmd(1, 1, 31, 2'b00, "R7");
        out_en_n = 1'b0; #1;
        check("R7 async on", {17'd0, dq_oe}, 18'd1);
        cmd(1, 1, 31, 2'b00, "R7");
        // R8 and R9: bursts in both orders and directions, and after deselect.
        burst_lin = 1'b1; cmd(1, 1, 6'd38, 2'b00, "R9");
        for (int k = 0; k < 4; k++) cmd(0, 0, 0, 2'b00, "R9");
        burst_lin = 1'b0; cmd(1, 1, 6'd45, 2'b00, "R9");
        for (int k = 0; k < 4; k++) cmd(0, 0, 0, 2'b00, "R9");
        burst_lin = 1'b1; cmd(1, 0, 6'd50, 2'b00, "R8");
        for (int k = 0; k < 3; k++) cmd(0, 1, 0, 2'b01, "R8");
        cmd(1, 1, 6'd50, 2'b00, "R8");
        for (int k = 0; k < 3; k++) cmd(0, 0, 0, 2'b00, "R8");
        sel2 = 1'b0; cmd(1, 1, 6'd2, 2'b00, "R8"); sel2 = 1'b1;
        for (int k = 0; k < 3; k++) cmd(0, 1, 0, 2'b00, "R8");
        // R1: seeded random traffic.
        for (int i = 0; i < 3000; i++) begin
            clk_en_n  = ($urandom % 8) == 0;
            sel1_n    = ($urandom % 12) == 0;
            sel2      = ($urandom % 12) != 0;
            sel3_n    = ($urandom % 12) == 0;
            adv_load  = ($urandom % 3) == 0;
            rd_wr_n   = $urandom % 2;
            burst_lin = $urandom % 2;
            addr      = AW'($urandom);
            byte_wr_n = 2'($urandom);
            out_en_n  = ($urandom % 10) == 0;
            dq_in     = DQW'($urandom);
            tick("R1");
        end
        summary();
    end

endmodule